// File: doc/BRIEF.md
# Register Pointer FIFO for a Router Input Port

This block is a small first-in first-out queue built entirely from flip-flops, intended to sit on an input or output port of an on-chip network router. Words arrive on a write port with a write request and leave on a read port with a read request. The upstream and downstream logic use the full and empty indications to decide when a request will be honoured.

Storage is a row of slot registers. A control unit keeps a write pointer, a read pointer and a single lap bit. A decoder steers each accepted incoming word into the slot the write pointer names. A selector picks the slot the read pointer names and loads it into a registered read-data output. Both pointers count modulo the depth. When the pointers coincide, the lap bit tells a full queue from an empty one. Depth and word width are parameters; the default is four slots of eight bits.

Requests that cannot be served are dropped without any change of state. A write to a full queue is dropped, and so is a read from an empty one. When the queue is empty, the read-data output goes on showing the word last delivered.

Top module: `reg_fifo`

## Requirements
- R1: While reset is held low at a clock edge, the block goes to the empty state. After that edge empty is 1, full is 0 and rd_data is 0.
- R2: Words leave in the order they were accepted. An accepted read loads the oldest word into rd_data on the clock edge that accepts it.
- R3: Starting from empty, DEPTH accepted writes with no reads raise full. Full stays low before that point, and empty drops after the first write.
- R4: A write request while full, with no read request, is dropped. Full stays 1, rd_data is unchanged, and the stored words later drain out unaltered.
- R5: A read request while empty, with no write request, is dropped. Empty stays 1 and rd_data keeps the last word delivered (0 straight after reset).
- R6: Simultaneous read and write requests, when the queue holds between 1 and DEPTH-1 words, are both carried out. The occupancy and both flags are unchanged.
- R7: Simultaneous requests while full carry out only the read. Full drops, and the offered write word is discarded.
- R8: Simultaneous requests while empty carry out only the write. Empty drops and rd_data is unchanged.
- R9: Pointers wrap modulo DEPTH. Order and flags stay correct over several fill and drain passes that begin at every pointer offset.
- R10: Full and empty are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | 1 | Request to store wr_data |
| rd_req | input | 1 | Request to deliver the oldest word |
| wr_data | input | WIDTH | Word to store |
| rd_data | output | WIDTH | Registered word last delivered |
| full | output | 1 | All DEPTH slots are occupied |
| empty | output | 1 | No slot is occupied |

## Verification
Every result of this block is due one rising edge after the requests that cause it. The flags, the pointers and rd_data all update on the edge that accepts a write or a read, so nothing arrives later. The bench applies each request pattern at a falling edge and lets one rising edge pass. It then samples full, empty and rd_data at the next falling edge, before the next pattern is applied. The expected values come from an occupancy count and a word queue kept in the bench. Each stimulus is checked against the value due exactly one edge later.

// File: rtl/reg_fifo_pkg.sv
// Package: shared helpers for the register FIFO.
// Assumes: depth is at least 2.
package reg_fifo_pkg;

    // Width of a pointer able to address every slot of a given depth.
    function automatic int ptr_width(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/reg_fifo_ctrl.sv
// Module: reg_fifo_ctrl
// Keeps the write pointer, read pointer and lap bit. Derives the write and
// read enables from the requests and the current state, and drives full and
// empty. Assumes DEPTH >= 2. The pointers count modulo DEPTH, so DEPTH need
// not be a power of two.
module reg_fifo_ctrl #(
    parameter int DEPTH = 4,
    parameter int PTR_W = reg_fifo_pkg::ptr_width(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             wr_en,
    output logic             rd_en,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic             lap_q;
    logic [PTR_W-1:0] wr_ptr_nx;
    logic [PTR_W-1:0] rd_ptr_nx;
    logic             same_slot;

    // Step a pointer forward by one, wrapping after the last slot.
    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
    endfunction

    // Status: equal pointers mean full or empty, and the lap bit decides which.
    always_comb begin
        same_slot = (wr_ptr == rd_ptr);
        full      = same_slot && lap_q;
        empty     = same_slot && !lap_q;
    end

    // Enables: accept only the requests the current state can serve.
    always_comb begin
        wr_en     = wr_req && !full;
        rd_en     = rd_req && !empty;
        wr_ptr_nx = step_ptr(wr_ptr);
        rd_ptr_nx = step_ptr(rd_ptr);
    end

    // Write pointer: advances on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (wr_en)
            wr_ptr <= wr_ptr_nx;
    end

    // Read pointer: advances on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (rd_en)
            rd_ptr <= rd_ptr_nx;
    end

    // Lap bit: set when a lone write catches up with the read pointer,
    // cleared when a lone read catches up with the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lap_q <= 1'b0;
        else if (wr_en && !rd_en && (wr_ptr_nx == rd_ptr))
            lap_q <= 1'b1;
        else if (rd_en && !wr_en && (rd_ptr_nx == wr_ptr))
            lap_q <= 1'b0;
    end

endmodule

// File: rtl/reg_fifo_slots.sv
// Module: reg_fifo_slots
// The storage row. A decoder on the write pointer picks one slot register,
// which loads the incoming word when the write enable is set. All slots are
// presented side by side for the output selector. Assumes wr_ptr < DEPTH.
module reg_fifo_slots #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    parameter int PTR_W = reg_fifo_pkg::ptr_width(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PTR_W-1:0]             wr_ptr,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0]  slots
);

    logic [DEPTH-1:0] slot_load;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Decoder: this slot loads when selected by an enabled write.
        always_comb slot_load[i] = wr_en && (wr_ptr == PTR_W'(i));

        // Slot register: holds its word until overwritten by a later lap.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[i] <= '0;
            else if (slot_load[i])
                slots[i] <= wr_data;
        end
    end

endmodule

// File: rtl/reg_fifo_rdsel.sv
// Module: reg_fifo_rdsel
// Output side. A selector on the read pointer picks one slot. The picked
// word is loaded into the output register on an accepted read, and is held
// otherwise. Assumes rd_ptr < DEPTH.
module reg_fifo_rdsel #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8,
    parameter int PTR_W = reg_fifo_pkg::ptr_width(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [PTR_W-1:0]             rd_ptr,
    input  logic [DEPTH-1:0][WIDTH-1:0]  slots,
    output logic [WIDTH-1:0]             rd_data
);

    logic [WIDTH-1:0] picked;

    // Selector: AND-OR pick of the slot named by the read pointer.
    always_comb begin
        picked = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ptr == PTR_W'(i))
                picked = picked | slots[i];
        end
    end

    // Output register: updates only on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= picked;
    end

endmodule

// File: rtl/reg_fifo.sv
// Module: reg_fifo (top)
// Flip-flop FIFO for a router port. Joins the pointer control, the slot row
// and the output selector. Assumes DEPTH >= 2 and WIDTH >= 1. Requests that
// cannot be served are dropped with no change of state.
module reg_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_req,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = reg_fifo_pkg::ptr_width(DEPTH);

    logic [PTR_W-1:0]            wr_ptr;
    logic [PTR_W-1:0]            rd_ptr;
    logic                        wr_en;
    logic                        rd_en;
    logic [DEPTH-1:0][WIDTH-1:0] slots;

    // Control: pointers, lap bit, enables and status.
    reg_fifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .rd_req (rd_req),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .full   (full),
        .empty  (empty)
    );

    // Storage: decoded slot registers.
    reg_fifo_slots #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .slots   (slots)
    );

    // Output: selector and registered read data.
    reg_fifo_rdsel #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) u_rdsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_ptr  (rd_ptr),
        .slots   (slots),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/reg_fifo_chk.sv
// Module: reg_fifo_chk
// Port-level properties of reg_fifo, attached to every instance by bind.
module reg_fifo_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_req,
    input logic             rd_req,
    input logic [WIDTH-1:0] rd_data,
    input logic             full,
    input logic             empty
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && rd_data == '0));

    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req) |=> (full && $stable(rd_data)));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_req) |=> (empty && $stable(rd_data)));

    // R7
    full_read_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_req) |=> !full);

    // R8
    empty_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && wr_req) |=> (!empty && $stable(rd_data)));

endmodule

bind reg_fifo reg_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty)
);

// File: tb/reg_fifo_test.sv
`timescale 1ns/1ps
// Bench: sweeps every occupancy and request pair at every pointer offset
// against a queue model. Inputs change at falling edges, checks at falling edges.
module reg_fifo_test;

    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_req = 1'b0;
    logic             rd_req = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic             full;
    logic             empty;

    int total = 0;
    int bad = 0;
    int seq = 0;
    logic [WIDTH-1:0] model_q[$];
    logic [WIDTH-1:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    reg_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .wr_data(wr_data), .rd_data(rd_data), .full(full), .empty(empty)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // One cycle of requests, entered and left at a falling edge.
    task automatic step(input bit w, input bit r, input string tag);
        int  sz;
        bit  w_ok;
        bit  r_ok;
        logic [WIDTH-1:0] d;
        d = WIDTH'(seq * 29 + 3);
        seq++;
        sz = model_q.size();
        w_ok = w && (sz < DEPTH);
        r_ok = r && (sz > 0);
        wr_req = w; rd_req = r; wr_data = d;
        if (r_ok) exp_rd = model_q.pop_front();
        if (w_ok) model_q.push_back(d);
        @(posedge clk);
        @(negedge clk);
        check(tag, "empty", int'(empty), int'(model_q.size() == 0));
        check(tag, "full", int'(full), int'(model_q.size() == DEPTH));
        check(tag, "rd_data", int'(rd_data), int'(exp_rd));
        check("R10", "both flags", int'(full && empty), 0);
        wr_req = 1'b0; rd_req = 1'b0;
    endtask

    // Tag for a request pair applied at a given occupancy.
    function automatic string pick_tag(input int occ, input bit w, input bit r);
        if (w && r) return (occ == 0) ? "R8" : (occ == DEPTH) ? "R7" : "R6";
        if (w && occ == DEPTH) return "R4";
        if (r && occ == 0) return "R5";
        return "R2";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state after reset edges
        check("R1", "empty", int'(empty), 1);
        check("R1", "full", int'(full), 0);
        check("R1", "rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        // R5: read on empty right after reset returns 0
        step(1'b0, 1'b1, "R5");
        for (int off = 0; off < DEPTH; off++) begin
            for (int occ = 0; occ <= DEPTH; occ++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int k = 0; k < occ; k++) step(1'b1, 1'b0, "R3");
                    step(op[0], op[1], pick_tag(occ, op[0], op[1]));
                    while (model_q.size() > 0) step(1'b0, 1'b1, "R9");
                end
            end
            // R9: move both pointers one slot on
            step(1'b1, 1'b0, "R9");
            step(1'b0, 1'b1, "R9");
        end
        // R2: long stream with overlapping traffic
        for (int k = 0; k < 3 * DEPTH; k++) step(1'b1, (k % 3) != 0, "R2");
        while (model_q.size() > 0) step(1'b0, 1'b1, "R2");
        finish_run();
    end

endmodule